// File: doc/BRIEF.md
# Host Bridge Control Register Bank

This block is the bank of control words that sits behind a host bridge's local register port. It answers full 32-bit word reads and writes over a small bus with address, write data, write strobe and read strobe lines. Most words are plain storage for configuration, general-purpose I/O setup, four mailbox words, cache control and timing settings. Other logic on the chip reads those settings.

Two words behave differently. The interrupt enable word cannot be written directly. Software changes it through two alias words: one ORs the written pattern into the enable word, the other clears the bits set in the written pattern. Each alias also keeps the last value written to it. The general configuration word watches its bit 2. When a write takes that bit from 0 to 1, the block issues a single-cycle system reset request. The current enable word and the interrupt status word are also driven out as ports, so the neighbouring interrupt logic can use them.

Top module: `nb_ctrl_regs`

## Requirements
- R1: The word index is the byte address with its two low bits dropped. Indices 0x00, 0x08 to 0x2C, 0x40 to 0x6C, 0x30 and 0x34 (byte offsets) store the written word, and a later read of the same offset returns it.
- R2: A write to offset 0x30 stores the word there and ORs it into the enable word at offset 0x38.
- R3: A write to offset 0x34 stores the word there and clears, in the enable word, every bit that is 1 in the written value.
- R4: Writes to offset 0x38 (enable) and to offset 0x3C (status) change nothing. The status word reads as 0.
- R5: A write to offset 0x04 always stores the new word. `sys_reset_req` is high for exactly the one cycle after the write edge, and only when bit 2 of the stored word was 0 and bit 2 of the new word is 1.
- R6: After reset, the words read as follows: 0x00 = 0x00000C40, 0x04 = 0x00001384, 0x08 = 0x2BFF8010, 0x0C = 0x255E0091, 0x10 = 0x00006140, 0x1C = 0x000001FF, 0x20 = 0x000001FF, 0x68 = 0x00000008, 0x6C = 0x10000000. Every other word reads 0.
- R7: Writes at byte offsets of 0x70 and above are dropped, and reads there return 0.
- R8: `bus_rdata` is loaded on the clock edge at which `bus_re` is sampled high, and it holds its value while `bus_re` is low.
- R9: `irq_enable` always equals the enable word, and `irq_status` equals the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| irq_enable | output | 32 | Current interrupt enable word |
| irq_status | output | 32 | Current interrupt status word |

## Verification
The bench walks the set and clear aliases in sequence, so a design that let one alias overwrite the enable word, rather than merge into it, would read back a wrong pattern at 0x38. It writes all-ones to the enable and status words, which exposes a design that decodes them as storage. It writes bit 2 of the general configuration word three ways: already set, cleared, and then set from 0. A trigger on level rather than on the rising transition would pulse when it should not, and a missing transition check would stay silent. Accesses at 0x70 and 0xFC check that an index that wraps or goes out of range neither aliases onto a real word nor returns stale data.

// File: rtl/nb_regs_pkg.sv
package nb_regs_pkg;

  localparam int unsigned NB_WORD_W      = 32;
  localparam int unsigned NB_IDX_GENCFG  = 1;
  localparam int unsigned NB_IDX_ENSET   = 12;
  localparam int unsigned NB_IDX_ENCLR   = 13;
  localparam int unsigned NB_IDX_EN      = 14;
  localparam int unsigned NB_IDX_STAT    = 15;
  localparam int unsigned NB_RESET_BIT   = 2;

  typedef logic [NB_WORD_W-1:0] nb_word_t;

  // Power-up value of each word, indexed by word (byte offset / 4).
  function automatic nb_word_t nb_default(input int unsigned idx);
    case (idx)
      0:       nb_default = 32'h0000_0C40;
      1:       nb_default = 32'h0000_1384;
      2:       nb_default = 32'h2BFF_8010;
      3:       nb_default = 32'h255E_0091;
      4:       nb_default = 32'h0000_6140;
      7:       nb_default = 32'h0000_01FF;
      8:       nb_default = 32'h0000_01FF;
      26:      nb_default = 32'h0000_0008;
      27:      nb_default = 32'h1000_0000;
      default: nb_default = '0;
    endcase
  endfunction

endpackage

// File: rtl/nb_addr_decode.sv
module nb_addr_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NWORDS = 28,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_win
);
  localparam int unsigned WIN_BYTES = NWORDS * 4;

  assign idx    = addr[IDX_W+1:2];
  assign in_win = (32'(addr) < WIN_BYTES);
endmodule

// File: rtl/nb_irq_enable.sv
module nb_irq_enable #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] enable
);
  always_ff @(posedge clk) begin
    if (rst)         enable <= '0;
    else if (set_we) enable <= enable | wdata;
    else if (clr_we) enable <= enable & ~wdata;
  end

  // R2: every bit written through the set alias is on afterwards
  p_set_merges_r2: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((enable & $past(wdata)) == $past(wdata)));
  // R3: every bit written through the clear alias is off afterwards
  p_clr_drops_r3: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((enable & $past(wdata)) == '0));
  // R4: no other access moves the enable word
  p_en_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(set_we || clr_we) |=> $stable(enable));
endmodule

// File: rtl/nb_reset_trigger.sv
module nb_reset_trigger (
  input  logic clk,
  input  logic rst,
  input  logic gen_we,
  input  logic old_bit,
  input  logic new_bit,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= gen_we && !old_bit && new_bit;
  end

  // R5: the request never lasts longer than one cycle
  p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
endmodule

// File: rtl/nb_ctrl_regs.sv
module nb_ctrl_regs
  import nb_regs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned WINDOW_BYTES = 112,
  localparam int unsigned NWORDS      = WINDOW_BYTES / 4,
  localparam int unsigned IDX_W       = $clog2(NWORDS),
  localparam int unsigned W           = NB_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [W-1:0]      bus_rdata,
  output logic              sys_reset_req,
  output logic [W-1:0]      irq_enable,
  output logic [W-1:0]      irq_status
);

  logic [IDX_W-1:0] idx;
  logic             in_win;
  logic             wr_hit;
  logic [W-1:0]     word_q [NWORDS];
  logic [W-1:0]     rd_sel;

  nb_addr_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
    .addr   (bus_addr),
    .idx    (idx),
    .in_win (in_win)
  );

  assign wr_hit = bus_we && in_win;

  nb_irq_enable #(.W(W)) u_en (
    .clk    (clk),
    .rst    (rst),
    .set_we (wr_hit && (32'(idx) == NB_IDX_ENSET)),
    .clr_we (wr_hit && (32'(idx) == NB_IDX_ENCLR)),
    .wdata  (bus_wdata),
    .enable (irq_enable)
  );

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    if (i == NB_IDX_EN) begin : g_en
      assign word_q[i] = irq_enable;
    end else if (i == NB_IDX_STAT) begin : g_stat
      assign word_q[i] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                 q <= nb_default(i);
        else if (wr_hit && (32'(idx) == 32'(i))) q <= bus_wdata;
      end
      assign word_q[i] = q;
    end
  end

  nb_reset_trigger u_rst_trig (
    .clk     (clk),
    .rst     (rst),
    .gen_we  (wr_hit && (32'(idx) == NB_IDX_GENCFG)),
    .old_bit (word_q[NB_IDX_GENCFG][NB_RESET_BIT]),
    .new_bit (bus_wdata[NB_RESET_BIT]),
    .req     (sys_reset_req)
  );

  assign irq_status = word_q[NB_IDX_STAT];

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NWORDS; k++)
      if (in_win && (32'(idx) == 32'(k))) rd_sel = word_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_sel;
  end

  // R7: reads beyond the window come back as zero
  p_oor_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (32'(bus_addr) >= WINDOW_BYTES)) |=> (bus_rdata == '0));
  // R8: read data holds while no read is issued
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/nb_ctrl_regs_test.sv
module nb_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;
  logic [31:0] irq_enable;
  logic [31:0] irq_status;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  nb_ctrl_regs uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sys_reset_req(sys_reset_req), .irq_enable(irq_enable), .irq_status(irq_status)
  );

  // {requirement, write addr, write data, read addr, expected read}
  localparam int NV = 15;
  localparam logic [83:0] VEC [NV] = '{
    {4'd1, 8'h00, 32'hDEADBEEF, 8'h00, 32'hDEADBEEF},  // R1
    {4'd1, 8'h08, 32'h12345678, 8'h08, 32'h12345678},  // R1
    {4'd1, 8'h2C, 32'hA5A5A5A5, 8'h2C, 32'hA5A5A5A5},  // R1
    {4'd1, 8'h40, 32'h11111111, 8'h40, 32'h11111111},  // R1 mailbox
    {4'd1, 8'h4C, 32'h44444444, 8'h4C, 32'h44444444},  // R1 mailbox
    {4'd1, 8'h6C, 32'hCAFEF00D, 8'h6C, 32'hCAFEF00D},  // R1
    {4'd2, 8'h30, 32'h000000F0, 8'h38, 32'h000000F0},  // R2
    {4'd2, 8'h30, 32'h00000003, 8'h38, 32'h000000F3},  // R2 merge
    {4'd3, 8'h34, 32'h00000031, 8'h38, 32'h000000C2},  // R3
    {4'd3, 8'h34, 32'h00000031, 8'h34, 32'h00000031},  // R3 alias stored
    {4'd2, 8'h30, 32'h00000100, 8'h30, 32'h00000100},  // R2 alias stored
    {4'd4, 8'h38, 32'hFFFFFFFF, 8'h38, 32'h000001C2},  // R4
    {4'd4, 8'h3C, 32'hFFFFFFFF, 8'h3C, 32'h00000000},  // R4
    {4'd7, 8'h70, 32'h00000001, 8'h70, 32'h00000000},  // R7
    {4'd7, 8'hFC, 32'h0000FFFF, 8'hFC, 32'h00000000}   // R7 index wrap
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6 reset values
    rd(8'h00, v); check(v == 32'h00000C40, "R6 0x00", v, 32'h00000C40);
    rd(8'h04, v); check(v == 32'h00001384, "R6 0x04", v, 32'h00001384);
    rd(8'h08, v); check(v == 32'h2BFF8010, "R6 0x08", v, 32'h2BFF8010);
    rd(8'h0C, v); check(v == 32'h255E0091, "R6 0x0C", v, 32'h255E0091);
    rd(8'h10, v); check(v == 32'h00006140, "R6 0x10", v, 32'h00006140);
    rd(8'h1C, v); check(v == 32'h000001FF, "R6 0x1C", v, 32'h000001FF);
    rd(8'h20, v); check(v == 32'h000001FF, "R6 0x20", v, 32'h000001FF);
    rd(8'h68, v); check(v == 32'h00000008, "R6 0x68", v, 32'h00000008);
    rd(8'h6C, v); check(v == 32'h10000000, "R6 0x6C", v, 32'h10000000);
    rd(8'h14, v); check(v == 32'h0, "R6 0x14", v, 32'h0);
    check(irq_enable == 32'h0, "R6 enable", irq_enable, 32'h0);
    check(sys_reset_req == 1'b0, "R6 req", {31'd0, sys_reset_req}, 32'h0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [83:0] e;
      e = VEC[i];
      wr(e[79:72], e[71:40]);
      rd(e[39:32], v);
      n_run++;
      if (v !== e[31:0]) begin
        n_fail++;
        $display("FAIL R%0d vector %0d actual=%08h expected=%08h", e[83:80], i, v, e[31:0]);
      end
    end

    // R9 ports follow the enable and status words
    check(irq_enable == 32'h000001C2, "R9 irq_enable", irq_enable, 32'h000001C2);
    check(irq_status == 32'h0, "R9 irq_status", irq_status, 32'h0);

    // R8 read data holds without a read strobe
    rd(8'h08, v);
    repeat (2) @(negedge clk);
    check(bus_rdata == 32'h12345678, "R8 hold", bus_rdata, 32'h12345678);

    // R5 bit 2 already set: no request
    wr(8'h04, 32'h00001384);
    check(sys_reset_req == 1'b0, "R5 1->1", {31'd0, sys_reset_req}, 32'h0);
    wr(8'h04, 32'h00000000);
    check(sys_reset_req == 1'b0, "R5 1->0", {31'd0, sys_reset_req}, 32'h0);
    rd(8'h04, v); check(v == 32'h0, "R5 stored", v, 32'h0);
    wr(8'h04, 32'h00000004);
    check(sys_reset_req == 1'b1, "R5 0->1 pulse", {31'd0, sys_reset_req}, 32'h1);
    @(negedge clk);
    check(sys_reset_req == 1'b0, "R5 pulse width", {31'd0, sys_reset_req}, 32'h0);
    rd(8'h04, v); check(v == 32'h4, "R5 stored new", v, 32'h4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule